// File: doc/BRIEF.md
# Branch-aware next program counter

This block produces the address of the next instruction for a processor with fixed four-byte instructions. Each cycle it takes the current program counter, a sign-extended branch displacement counted in instructions, and three control bits. The bits are a conditional-branch flag from the control unit, an unconditional-branch flag, and the zero flag from the ALU. From these it forms either the sequential address or the branch target. The displacement is scaled to bytes by a left shift before it is added, so a negative displacement reaches backward. All address arithmetic wraps modulo 2^XLEN.

The block also holds the program counter register. A synchronous reset loads it with a parameterised reset vector, and it takes the computed next address on a rising clock edge only while the advance enable is high. A stall is a plain low level on that enable, so there is no handshake. The next address is also brought out combinationally, so the fetch stage can use it in the same cycle.

Top module: `next_pc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc` is loaded with `RESET_VEC` (default zero), whatever the value of `adv_en`.
- R2: With both `cond_br` and `uncond_br` low, `next_pc` equals `pc + INSTR_BYTES` (4 by default), wrapping modulo 2^XLEN.
- R3: The branch target is `pc + (br_off << log2(INSTR_BYTES))`, computed in two's complement and truncated to XLEN bits.
- R4: With `cond_br` high and `alu_zero` high, `next_pc` equals the branch target.
- R5: With `cond_br` high, `alu_zero` low and `uncond_br` low, `next_pc` equals `pc + INSTR_BYTES`.
- R6: With `uncond_br` high, `next_pc` equals the branch target, whatever the values of `alu_zero` and `cond_br`.
- R7: Outside reset, `pc` takes the value `next_pc` had before a rising edge when `adv_en` was high, and keeps its value when `adv_en` was low.
- R8: A negative `br_off` (all ones meaning -1) gives a target below `pc`. For example, `pc` 0x1000 with -1 gives 0x0FFC.
- R9: `next_pc` follows `pc` and the control inputs combinationally, in the same cycle and with no register in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the PC register updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Advance enable; low stalls the PC register |
| cond_br | input | 1 | Current instruction is a conditional branch |
| uncond_br | input | 1 | Current instruction is an unconditional branch |
| alu_zero | input | 1 | Zero result flag from the ALU |
| br_off | input | XLEN | Sign-extended branch displacement, in instructions |
| pc | output | XLEN | Registered program counter |
| next_pc | output | XLEN | Combinational next program counter |

## Verification
The bench builds two copies of the block. The first uses the default 64-bit width with a reset vector of 0x1000. It runs directed cases for backward targets, wrap-around and stalls, then random displacements across all eight flag combinations while the register is clocked. The second is 6 bits wide with a zero reset vector. At that size every aligned PC value, every displacement and every flag combination can be enumerated, about eight thousand vectors. Those vectors include every case where the target or the increment wraps past the top of the address space.

// File: rtl/next_pc_pkg.sv
`timescale 1ns / 1ps
package next_pc_pkg;

  // Source picked for the next program counter
  typedef enum logic {
    SRC_SEQ  = 1'b0,
    SRC_JUMP = 1'b1
  } pc_src_e;

  // Branch resolution: jump when unconditional, or conditional with zero set
  function automatic pc_src_e resolve_src(input logic cond, input logic zero,
                                          input logic uncond);
    return (uncond || (cond && zero)) ? SRC_JUMP : SRC_SEQ;
  endfunction

endpackage

// File: rtl/pc_seq_incr.sv
`timescale 1ns / 1ps
module pc_seq_incr #(
  parameter int XLEN = 64,
  parameter int STEP = 4
) (
  input  logic [XLEN-1:0] cur_pc,
  output logic [XLEN-1:0] seq_pc
);
  localparam logic [XLEN-1:0] STEP_V = XLEN'(STEP);

  // Constant increment, wraps naturally at XLEN bits
  always_comb seq_pc = cur_pc + STEP_V;
endmodule

// File: rtl/pc_target_add.sv
`timescale 1ns / 1ps
module pc_target_add #(
  parameter int XLEN  = 64,
  parameter int SHIFT = 2
) (
  input  logic [XLEN-1:0] cur_pc,
  input  logic [XLEN-1:0] disp,
  output logic [XLEN-1:0] tgt_pc
);
  logic [XLEN-1:0] disp_bytes;

  generate
    if (SHIFT == 0) begin : g_byte_disp
      always_comb disp_bytes = disp;
    end else begin : g_scaled_disp
      // Instruction count to byte count; sign is kept modulo 2^XLEN
      always_comb disp_bytes = disp << SHIFT;
    end
  endgenerate

  always_comb tgt_pc = cur_pc + disp_bytes;
endmodule

// File: rtl/pc_src_mux.sv
`timescale 1ns / 1ps
module pc_src_mux
  import next_pc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            cond,
  input  logic            zero,
  input  logic            uncond,
  input  logic [XLEN-1:0] seq_pc,
  input  logic [XLEN-1:0] tgt_pc,
  output logic [XLEN-1:0] nxt_pc
);
  pc_src_e src;

  always_comb begin
    src = resolve_src(cond, zero, uncond);
    unique case (src)
      SRC_JUMP: nxt_pc = tgt_pc;
      default:  nxt_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/next_pc_unit.sv
`timescale 1ns / 1ps
module next_pc_unit #(
  parameter int              XLEN        = 64,
  parameter int              INSTR_BYTES = 4,
  parameter logic [XLEN-1:0] RESET_VEC   = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_en,
  input  logic            cond_br,
  input  logic            uncond_br,
  input  logic            alu_zero,
  input  logic [XLEN-1:0] br_off,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] next_pc
);
  localparam int SHIFT = $clog2(INSTR_BYTES);

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] seq_w;
  logic [XLEN-1:0] tgt_w;
  logic [XLEN-1:0] nxt_w;

  pc_seq_incr #(.XLEN(XLEN), .STEP(INSTR_BYTES)) u_seq (
    .cur_pc (pc_q),
    .seq_pc (seq_w)
  );

  pc_target_add #(.XLEN(XLEN), .SHIFT(SHIFT)) u_tgt (
    .cur_pc (pc_q),
    .disp   (br_off),
    .tgt_pc (tgt_w)
  );

  pc_src_mux #(.XLEN(XLEN)) u_mux (
    .cond   (cond_br),
    .zero   (alu_zero),
    .uncond (uncond_br),
    .seq_pc (seq_w),
    .tgt_pc (tgt_w),
    .nxt_pc (nxt_w)
  );

  always_ff @(posedge clk) begin
    if (rst)         pc_q <= RESET_VEC;
    else if (adv_en) pc_q <= nxt_w;
  end

  assign pc      = pc_q;
  assign next_pc = nxt_w;

  // R1
  reset_load_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> pc_q == RESET_VEC);

  // R7
  advance_load_chk: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> pc_q == $past(nxt_w));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> pc_q == $past(pc_q));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!cond_br && !uncond_br) |-> nxt_w == seq_w);

  // R4
  cond_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_br && alu_zero) |-> nxt_w == tgt_w);

  // R5
  cond_fallthru_chk: assert property (@(posedge clk) disable iff (rst)
    (cond_br && !alu_zero && !uncond_br) |-> nxt_w == seq_w);

  // R6
  uncond_jump_chk: assert property (@(posedge clk) disable iff (rst)
    uncond_br |-> nxt_w == tgt_w);
endmodule

// File: tb/test_next_pc_unit.sv
`timescale 1ns / 1ps
module test_next_pc_unit;
  localparam logic [63:0] WIDE_RV = 64'h0000_0000_0000_1000;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  // wide instance
  logic        w_rst, w_en, w_cb, w_ub, w_z;
  logic [63:0] w_off, w_pc, w_nx;
  // narrow instance
  logic        n_rst, n_en, n_cb, n_ub, n_z;
  logic [5:0]  n_off, n_pc, n_nx;

  int  vecs = 0;
  int  bad  = 0;
  bit  done = 1'b0;

  next_pc_unit #(.XLEN(64), .INSTR_BYTES(4), .RESET_VEC(WIDE_RV)) i_next_pc_unit (
    .clk(clk), .rst(w_rst), .adv_en(w_en), .cond_br(w_cb), .uncond_br(w_ub),
    .alu_zero(w_z), .br_off(w_off), .pc(w_pc), .next_pc(w_nx)
  );

  next_pc_unit #(.XLEN(6), .INSTR_BYTES(4), .RESET_VEC(6'd0)) i_next_pc_unit_narrow (
    .clk(clk), .rst(n_rst), .adv_en(n_en), .cond_br(n_cb), .uncond_br(n_ub),
    .alu_zero(n_z), .br_off(n_off), .pc(n_pc), .next_pc(n_nx)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_wide(input logic [63:0] p, input logic [63:0] o,
                                           input logic cb, input logic z, input logic ub);
    return (ub || (cb && z)) ? p + (o << 2) : p + 64'd4;
  endfunction

  function automatic string tag_of(input logic cb, input logic z, input logic ub);
    if (ub)            return "R6";
    else if (cb && z)  return "R4";
    else if (cb)       return "R5";
    return "R2";
  endfunction

  task automatic wide_set(input logic cb, input logic z, input logic ub, input logic [63:0] o);
    w_cb = cb; w_z = z; w_ub = ub; w_off = o;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, bad);
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] exp_pc;
    w_rst = 1'b1; w_en = 1'b0; wide_set(1'b0, 1'b0, 1'b0, 64'd0);
    n_rst = 1'b1; n_en = 1'b0; n_cb = 1'b0; n_z = 1'b0; n_ub = 1'b0; n_off = 6'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 wide reset", w_pc, WIDE_RV);
    chk("R1 narrow reset", {58'd0, n_pc}, 64'd0);
    #1 chk("R2 sequential after reset", w_nx, WIDE_RV + 64'd4);
    w_rst = 1'b0; n_rst = 1'b0;

    // directed, wide, PC held at 0x1000
    @(negedge clk); wide_set(1'b1, 1'b1, 1'b0, 64'd2);
    #1 chk("R4 taken", w_nx, 64'h1008);
    @(negedge clk); wide_set(1'b1, 1'b0, 1'b0, 64'd3);
    #1 chk("R5 not taken", w_nx, 64'h1004);
    @(negedge clk); wide_set(1'b0, 1'b0, 1'b1, 64'd4);
    #1 chk("R6 unconditional", w_nx, 64'h1010);
    @(negedge clk); wide_set(1'b1, 1'b0, 1'b1, 64'd4);
    #1 chk("R6 both flags zero low", w_nx, 64'h1010);
    @(negedge clk); wide_set(1'b0, 1'b0, 1'b1, '1);
    #1 chk("R8 backward by one", w_nx, 64'h0FFC);
    @(negedge clk); wide_set(1'b0, 1'b1, 1'b1, 64'h4000_0000_0000_0000);
    #1 chk("R3 scaled wrap", w_nx, 64'h1000);
    @(negedge clk); wide_set(1'b0, 1'b1, 1'b0, 64'd9);
    #1 chk("R9 same-cycle next_pc", w_nx, 64'h1004);

    // advance then stall
    @(negedge clk); w_en = 1'b1; wide_set(1'b0, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFE);
    @(posedge clk); @(negedge clk);
    chk("R7 advance", w_pc, 64'h0FF8);
    w_en = 1'b0; wide_set(1'b0, 1'b0, 1'b1, 64'd5);
    @(posedge clk); @(negedge clk);
    chk("R7 stall holds", w_pc, 64'h0FF8);

    // random, wide, clocked
    for (int i = 0; i < 1500; i++) begin
      logic [63:0] o;
      logic [63:0] e;
      o = (i % 3 == 0) ? {{56{$urandom_range(1) == 1}}, 8'($urandom)} : {$urandom, $urandom};
      wide_set(i[0], i[1], i[2], o);
      w_en = ($urandom_range(3) != 0);
      #1;
      e = ref_wide(w_pc, o, i[0], i[1], i[2]);
      chk({tag_of(i[0], i[1], i[2]), " R3 random"}, w_nx, e);
      exp_pc = w_en ? e : w_pc;
      @(posedge clk); @(negedge clk);
      chk("R7 random update", w_pc, exp_pc);
    end

    // reset overrides enable
    w_rst = 1'b1; w_en = 1'b1; wide_set(1'b0, 1'b0, 1'b1, 64'd77);
    @(posedge clk); @(negedge clk);
    chk("R1 reset beats enable", w_pc, WIDE_RV);
    w_rst = 1'b0; w_en = 1'b0;

    // exhaustive, narrow
    for (int t = 0; t < 16; t++) begin
      @(negedge clk);
      n_en = 1'b1; n_ub = 1'b1; n_cb = 1'b0; n_z = 1'b0;
      n_off = 6'((((t * 4) - int'(n_pc)) & 63) >> 2);
      @(posedge clk); @(negedge clk);
      n_en = 1'b0;
      chk("R7 narrow move", {58'd0, n_pc}, 64'(t * 4));
      for (int o = 0; o < 64; o++) begin
        for (int f = 0; f < 8; f++) begin
          int e6;
          @(negedge clk);
          n_off = 6'(o); n_cb = f[0]; n_z = f[1]; n_ub = f[2];
          #1;
          e6 = (f[2] || (f[0] && f[1])) ? ((t * 4 + o * 4) & 63) : ((t * 4 + 4) & 63);
          chk({tag_of(f[0], f[1], f[2]), " R3 narrow sweep"}, {58'd0, n_nx}, 64'(e6));
        end
      end
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule